// File: doc/BRIEF.md
# Protected Access Policy Register File

This block holds a parameterised set of access-control policies as memory-mapped 32-bit registers. Each policy word pairs a read-permission bitmap with a write-permission bitmap, one bit per 4-bit role. All policies are driven out continuously as one flat vector, so that the register checkers elsewhere in the chip can look up whether a role may touch the objects a policy governs.

The policy registers are reached over a simple request/response register bus. Every request carries the role of its originator. Access to the policy registers is itself guarded by a fixed, design-time root-private policy. That policy's two bitmaps are parameters and never come from the writable registers, so software cannot widen its own rights. Reset contents come from a parameter. A denied access always completes, with zero data and no change of state. A parameter selects whether the denial is also flagged as a bus error.

A small controller with two states sequences each access. `ST_IDLE` (ready high) takes a request on the ACCEPT transition when `req_valid` is high. It then moves to `ST_RESP`, where the response is presented for exactly one cycle. The COMPLETE transition returns it unconditionally to `ST_IDLE`. Any permitted write lands on the same clock edge as ACCEPT.

Top module: `acl_policy_regfile`

## Requirements
- R1: After reset `pol_vec` equals the `RST_POLICIES` parameter, `rsp_valid` is 0, `rsp_err` is 0 and `req_ready` is 1.
- R2: Policy k occupies byte offset 8*k. In its word, bits 15:0 hold the read bitmap and bits 31:16 hold the write bitmap, and bit r of each bitmap belongs to role r. A permitted read returns the word. Policy k appears on `pol_vec[32*k+31:32*k]`.
- R3: The word at offset 8*k+4 is reserved. A permitted read of it returns 0 without error, and a permitted write to it changes no policy.
- R4: A read is permitted only if bit `req_role` of `ROOT_RD` is 1. A denied read returns all-zero data.
- R5: A write is permitted only if bit `req_role` of `ROOT_WR` is 1. A denied write leaves `pol_vec` unchanged.
- R6: An access is denied unless `req_addr[1:0]` is 0 and `req_be` is 4'hF (whole, aligned 32-bit words only).
- R7: An access at an offset of 8*`NUM_POL` or above is denied.
- R8: `rsp_err` is 1 for a denied access exactly when `ERR_RSP` is 1, and it is 0 for every permitted access.
- R9: A request is taken when `req_valid` and `req_ready` are both 1. `rsp_valid` is 1 in the next cycle only, and `req_ready` is 0 during that cycle.
- R10: A permitted write updates only the addressed policy, with the value of `req_wdata`, visible on `pol_vec` from the cycle of the response.
- R11: The rights on the policy registers stay those of `ROOT_RD`/`ROOT_WR` whatever values are written into any policy, including policy 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte offset |
| req_be | input | 4 | Byte enables |
| req_wdata | input | 32 | Write data |
| req_role | input | 4 | Role of the originator |
| rsp_valid | output | 1 | Response present (one cycle) |
| rsp_rdata | output | 32 | Read data, zero on denial and on writes |
| rsp_err | output | 1 | Bus error on a denied access |
| pol_vec | output | 32*NUM_POL | All policies, policy 0 in the low word |

## Verification
Directed accesses separate the causes of a denial: a role missing from the write bitmap but present in the read bitmap, a role missing from both, a misaligned offset, a partial byte-enable pattern and an out-of-range offset. The reserved words are tried with a permitted role, to show that the zero data there is not caused by a denial. One write opens policy 0 to every role, and a later unprivileged access is still denied, which shows the guard does not read the writable registers. Seeded random traffic over roles, offsets, byte enables and data is then checked against a bench model, on two instances that differ only in the error-response parameter.

// File: rtl/acl_pkg.sv
package acl_pkg;
    localparam int WORD_W = 32;
    localparam int PERM_W = 16;
    localparam int ROLE_W = 4;
    localparam int BE_W   = WORD_W / 8;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } acl_state_e;
endpackage

// File: rtl/acl_access_decode.sv
module acl_access_decode #(
    parameter int                          NUM_POL = 4,
    parameter int                          AW      = 8,
    parameter logic [acl_pkg::PERM_W-1:0]  ROOT_RD = 16'h0001,
    parameter logic [acl_pkg::PERM_W-1:0]  ROOT_WR = 16'h0001,
    localparam int                         IW      = (NUM_POL > 1) ? $clog2(NUM_POL) : 1
) (
    input  logic                        we,
    input  logic [AW-1:0]               addr,
    input  logic [acl_pkg::BE_W-1:0]    be,
    input  logic [acl_pkg::ROLE_W-1:0]  role,
    output logic [IW-1:0]               idx,
    output logic                        resv,
    output logic                        granted
);
    localparam int XW = AW - 3;

    logic [XW-1:0] word_idx;
    logic          aligned;
    logic          in_range;
    logic          perm;

    always_comb begin
        word_idx = addr[AW-1:3];
        idx      = word_idx[IW-1:0];
        resv     = addr[2];
        aligned  = (addr[1:0] == 2'b00) && (be == {acl_pkg::BE_W{1'b1}});
        in_range = (32'(word_idx) < 32'(NUM_POL));
        perm     = we ? ROOT_WR[role] : ROOT_RD[role];
        granted  = aligned && in_range && perm;
    end
endmodule

// File: rtl/acl_policy_store.sv
module acl_policy_store #(
    parameter int                               NUM_POL      = 4,
    parameter logic [NUM_POL*acl_pkg::WORD_W-1:0] RST_POLICIES = {NUM_POL{32'h0001_0001}},
    localparam int                              IW           = (NUM_POL > 1) ? $clog2(NUM_POL) : 1,
    localparam int                              VW           = NUM_POL * acl_pkg::WORD_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [IW-1:0]               idx,
    input  logic [acl_pkg::WORD_W-1:0]  wdata,
    output logic [acl_pkg::WORD_W-1:0]  rd_word,
    output logic [VW-1:0]               pol_vec
);
    localparam int W = acl_pkg::WORD_W;

    logic [NUM_POL-1:0] pol_we;

    for (genvar k = 0; k < NUM_POL; k++) begin : g_pol
        logic [W-1:0] word_q;

        assign pol_we[k] = wr_en && (idx == IW'(k));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= RST_POLICIES[k*W +: W];
            end else if (pol_we[k]) begin
                word_q <= wdata;
            end
        end

        assign pol_vec[k*W +: W] = word_q;
    end

    always_comb begin
        rd_word = '0;
        for (int k = 0; k < NUM_POL; k++) begin
            if (idx == IW'(k)) begin
                rd_word = pol_vec[k*W +: W];
            end
        end
    end

    // R10: at most one policy register is written per cycle
    p_single_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pol_we));
endmodule

// File: rtl/acl_policy_regfile.sv
module acl_policy_regfile #(
    parameter int                                 NUM_POL      = 4,
    parameter int                                 AW           = 8,
    parameter logic [NUM_POL*acl_pkg::WORD_W-1:0] RST_POLICIES = {NUM_POL{32'h0001_0001}},
    parameter logic [acl_pkg::PERM_W-1:0]         ROOT_RD      = 16'h0001,
    parameter logic [acl_pkg::PERM_W-1:0]         ROOT_WR      = 16'h0001,
    parameter bit                                 ERR_RSP      = 1'b1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                req_valid,
    output logic                                req_ready,
    input  logic                                req_we,
    input  logic [AW-1:0]                       req_addr,
    input  logic [acl_pkg::BE_W-1:0]            req_be,
    input  logic [acl_pkg::WORD_W-1:0]          req_wdata,
    input  logic [acl_pkg::ROLE_W-1:0]          req_role,
    output logic                                rsp_valid,
    output logic [acl_pkg::WORD_W-1:0]          rsp_rdata,
    output logic                                rsp_err,
    output logic [NUM_POL*acl_pkg::WORD_W-1:0]  pol_vec
);
    import acl_pkg::*;

    localparam int IW = (NUM_POL > 1) ? $clog2(NUM_POL) : 1;

    acl_state_e         state_q, state_d;
    logic               fire;
    logic [IW-1:0]      idx;
    logic               resv;
    logic               granted;
    logic               wr_en;
    logic [WORD_W-1:0]  rd_word;

    acl_access_decode #(
        .NUM_POL (NUM_POL),
        .AW      (AW),
        .ROOT_RD (ROOT_RD),
        .ROOT_WR (ROOT_WR)
    ) u_decode (
        .we      (req_we),
        .addr    (req_addr),
        .be      (req_be),
        .role    (req_role),
        .idx     (idx),
        .resv    (resv),
        .granted (granted)
    );

    assign fire  = req_valid && req_ready;
    assign wr_en = fire && req_we && granted && !resv;

    acl_policy_store #(
        .NUM_POL      (NUM_POL),
        .RST_POLICIES (RST_POLICIES)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .idx     (idx),
        .wdata   (req_wdata),
        .rd_word (rd_word),
        .pol_vec (pol_vec)
    );

    // next-state logic: ACCEPT and COMPLETE transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign req_ready = (state_q == ST_IDLE);
    assign rsp_valid = (state_q == ST_RESP);

    // output register: response data and error captured on ACCEPT
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end else if (fire) begin
            rsp_rdata <= (granted && !req_we && !resv) ? rd_word : '0;
            rsp_err   <= ERR_RSP && !granted;
        end else begin
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end
    end

    // R9: an accepted request is answered in the next cycle
    p_rsp_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (rsp_valid && !req_ready));

    // R9: response lasts one cycle
    p_rsp_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R4: an error response never carries data
    p_zero_on_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_rdata == '0));

    // R5: a write by a role outside the root write bitmap changes nothing
    p_denied_wr_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && req_we && !ROOT_WR[req_role]) |=> $stable(pol_vec));

    // R3: reserved word reads as zero
    p_resv_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !req_we && req_addr[2]) |=> (rsp_rdata == '0));

    // R8: no error flag when error responses are disabled
    p_no_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !ERR_RSP) |-> !rsp_err);

    // R6: partial accesses never modify policies
    p_partial_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && req_we && (req_be != 4'hF)) |=> $stable(pol_vec));
endmodule

// File: tb/acl_policy_regfile_tb_top.sv
module acl_policy_regfile_tb_top;
    localparam int NP = 4;
    localparam int AW = 8;
    localparam logic [NP*32-1:0] RST = {32'h0003_0007, 32'h0001_0001,
                                        32'h000F_000F, 32'h0001_0003};
    localparam logic [15:0] RRD = 16'h0003;
    localparam logic [15:0] RWR = 16'h0001;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_we = 1'b0;
    logic [AW-1:0]   req_addr = '0;
    logic [3:0]      req_be = 4'hF;
    logic [31:0]     req_wdata = '0;
    logic [3:0]      req_role = '0;
    logic            req_ready, rsp_valid, rsp_err;
    logic [31:0]     rsp_rdata;
    logic [NP*32-1:0] pol_vec;
    logic            n_ready, n_valid, n_err;
    logic [31:0]     n_rdata;
    logic [NP*32-1:0] n_vec;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [31:0] model [NP];

    always #2 clk = ~clk;

    acl_policy_regfile #(.NUM_POL(NP), .AW(AW), .RST_POLICIES(RST),
        .ROOT_RD(RRD), .ROOT_WR(RWR), .ERR_RSP(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_addr(req_addr), .req_be(req_be),
        .req_wdata(req_wdata), .req_role(req_role), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .pol_vec(pol_vec));

    acl_policy_regfile #(.NUM_POL(NP), .AW(AW), .RST_POLICIES(RST),
        .ROOT_RD(RRD), .ROOT_WR(RWR), .ERR_RSP(1'b0)) dut_noerr_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(n_ready),
        .req_we(req_we), .req_addr(req_addr), .req_be(req_be),
        .req_wdata(req_wdata), .req_role(req_role), .rsp_valid(n_valid),
        .rsp_rdata(n_rdata), .rsp_err(n_err), .pol_vec(n_vec));

    task automatic check(input bit ok, input string rq,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic bit exp_grant(input bit we, input logic [AW-1:0] a,
                                     input logic [3:0] be, input logic [3:0] role);
        bit perm = we ? RWR[role] : RRD[role];
        return (a[1:0] == 2'b00) && (be == 4'hF) && (int'(a[AW-1:3]) < NP) && perm;
    endfunction

    function automatic logic [NP*32-1:0] model_vec();
        logic [NP*32-1:0] v;
        for (int k = 0; k < NP; k++) v[k*32 +: 32] = model[k];
        return v;
    endfunction

    task automatic access(input bit we, input logic [AW-1:0] a, input logic [3:0] be,
                          input logic [31:0] wd, input logic [3:0] role, input string rq);
        bit g = exp_grant(we, a, be, role);
        logic [31:0] ed;
        int ix = int'(a[AW-1:3]);
        ed = (g && !we && !a[2]) ? model[ix] : 32'h0;
        @(negedge clk);
        check(req_ready == 1'b1, "R9 ready idle", 128'(req_ready), 128'(1));
        req_valid = 1'b1; req_we = we; req_addr = a; req_be = be;
        req_wdata = wd; req_role = role;
        @(negedge clk);
        req_valid = 1'b0;
        if (g && we && !a[2]) model[ix] = wd;
        check(rsp_valid && !req_ready, {"R9 rsp ", rq}, 128'({rsp_valid, req_ready}), 128'(2'b10));
        check(rsp_rdata == ed, {"R2/R4 rdata ", rq}, 128'(rsp_rdata), 128'(ed));
        check(rsp_err == !g, {"R8 err ", rq}, 128'(rsp_err), 128'(!g));
        check(n_err == 1'b0 && n_rdata == ed, {"R8 noerr ", rq}, 128'({n_err, n_rdata}), 128'({1'b0, ed}));
        check(pol_vec == model_vec(), {"R10 vec ", rq}, pol_vec, model_vec());
        @(negedge clk);
        check(rsp_valid == 1'b0, "R9 single", 128'(rsp_valid), 128'(0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int k = 0; k < NP; k++) model[k] = RST[k*32 +: 32];
        repeat (3) @(negedge clk);
        // R1 reset state
        check(pol_vec == RST, "R1 vec", pol_vec, RST);
        check(!rsp_valid && !rsp_err && req_ready, "R1 ctl",
              128'({rsp_valid, rsp_err, req_ready}), 128'(3'b001));
        rst_n = 1'b1;
        // R2 layout: read every policy with role 0
        for (int k = 0; k < NP; k++) access(1'b0, AW'(8*k), 4'hF, 0, 4'd0, "R2 read");
        access(1'b1, 8'h10, 4'hF, 32'hA5A5_0101, 4'd0, "R10 wr p2");
        access(1'b0, 8'h10, 4'hF, 0, 4'd1, "R4 role1 read ok");
        access(1'b1, 8'h08, 4'hF, 32'hFFFF_FFFF, 4'd1, "R5 role1 wr deny");
        access(1'b0, 8'h08, 4'hF, 0, 4'd2, "R4 role2 rd deny");
        access(1'b0, 8'h0C, 4'hF, 0, 4'd0, "R3 resv rd");
        access(1'b1, 8'h0C, 4'hF, 32'h1234_5678, 4'd0, "R3 resv wr");
        access(1'b1, 8'h09, 4'hF, 32'h1, 4'd0, "R6 misaligned");
        access(1'b1, 8'h08, 4'h3, 32'h1, 4'd0, "R6 partial be");
        access(1'b0, AW'(8*NP), 4'hF, 0, 4'd0, "R7 out of range");
        access(1'b1, 8'h00, 4'hF, 32'hFFFF_FFFF, 4'd0, "R11 open p0");
        access(1'b1, 8'h18, 4'hF, 32'h0, 4'd3, "R11 role3 still denied");
        access(1'b0, 8'h00, 4'hF, 0, 4'd2, "R11 role2 rd denied");
        for (int i = 0; i < 400; i++) begin
            logic [AW-1:0] a = AW'($urandom % (8*NP + 16));
            logic [3:0] be = ($urandom % 8 == 0) ? 4'($urandom) : 4'hF;
            if ($urandom % 4 != 0) a[1:0] = 2'b00;
            access(1'($urandom), a, be, $urandom, 4'($urandom % 4), "random");
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule